// File: doc/BRIEF.md
# Nybble-Symbol Chipkill ECC Codec

This block guards a 128-bit memory word with 16 check bits. The 144 stored bits are treated as 36 four-bit symbols: 32 data symbols and 4 check symbols. Each symbol is one element of GF(16). The encode side is purely combinational. It turns a write word into its 16 check bits. The decode side takes a stored word and its check bits. It recomputes the checks and XORs them with the stored ones to form a 16-bit syndrome. From that syndrome it repairs any error that stays inside one aligned nybble, or it reports the word as uncorrectable when two symbols are hit. Because a whole nybble is repaired, the loss of one x4 DRAM device is survived.

The parity-check columns are points of an elliptic quadric in three-dimensional projective space over GF(16). No three such points lie on a line. As a result, each nonzero single-symbol syndrome matches exactly one column, and no sum of two columns matches a third. The decode path has one register stage with a valid/ready handshake.

Top module: `nyb_chipkill_codec`

## Requirements
- R1: Field arithmetic uses GF(16) with polynomial x^4+x+1; bit 0 is the constant term. Data symbol j is bits 4j+3..4j. Take a = j mod 16, b = 2 for j<16, and b = 3 for j>=16. Data symbol j adds d·(1+a+b) to check symbol 0, d·a to check symbol 1, d·b to check symbol 2, and d·(a²+ab+8b²+a+8b) to check symbol 3. Check symbol k is enc_check[4k+3:4k].
- R2: A word whose syndrome is zero is passed through unchanged, with out_ce=0, out_ue=0, out_sym=0 and out_upper=0.
- R3: Any nonzero error pattern in data symbol j (0..31) is corrected. The output shows out_ce=1, out_ue=0 and out_sym=j.
- R4: Any nonzero error pattern in check symbol k is reported with out_ce=1 and out_sym=32+k. The data output stays equal to the received data.
- R5: Nonzero errors in two distinct symbols give out_ue=1 and out_ce=0. The data is passed uncorrected, with out_sym=0.
- R6: out_syndrome equals the checks recomputed from in_data XOR in_check. For a single error e in symbol i, it equals e times column i. Check symbol k's column is the k-th unit vector.
- R7: out_upper is 1 exactly when a corrected data symbol lies in 16..31, that is, in bits 127..64 (the upper 64-bit DIMM).
- R8: in_ready = !out_valid || out_ready. While out_valid=1 and out_ready=0, all outputs hold.
- R9: After reset, out_valid is 0 and in_ready is 1.
- R10: A word accepted on a clock edge (in_valid && in_ready) appears on the outputs right after that edge, with out_valid=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_data | input | 128 | Write-path data |
| enc_check | output | 16 | Check bits for enc_data |
| in_valid | input | 1 | Read word valid |
| in_ready | output | 1 | Decoder can accept a word |
| in_data | input | 128 | Read-path data |
| in_check | input | 16 | Read-path stored check bits |
| out_valid | output | 1 | Decoded result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_data | output | 128 | Corrected data |
| out_ce | output | 1 | Single-symbol error corrected |
| out_ue | output | 1 | Uncorrectable error |
| out_syndrome | output | 16 | Syndrome, symbol k in bits 4k+3..4k |
| out_sym | output | 6 | Index of the corrected symbol (0..35) |
| out_upper | output | 1 | Corrected symbol lies in the upper 64 bits |

## Verification
The hardest cases to reach are the two-symbol errors. Their sum happens to equal a scaled copy of a third column only if the code construction is wrong, so only a broad spread of symbol pairs and magnitudes can expose such a flaw. The bench first runs every nonzero pattern at every one of the 36 positions on random data words. It then drives several hundred random pairs of distinct symbols with random nonzero magnitudes, and checks that each one is flagged uncorrectable. Expected syndromes come from a separate carry-less multiply-then-reduce model of the check equations.

// File: rtl/nyb_chipkill_codec.sv
module nyb_chipkill_codec (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [127:0] enc_data,
  output logic [15:0]  enc_check,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] in_data,
  input  logic [15:0]  in_check,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] out_data,
  output logic         out_ce,
  output logic         out_ue,
  output logic [15:0]  out_syndrome,
  output logic [5:0]   out_sym,
  output logic         out_upper
);
  localparam int NDATA = 32;
  localparam int NCHK  = 4;
  localparam int NSYM  = NDATA + NCHK;
  localparam logic [3:0] QC = 4'h8;

  function automatic logic [3:0] gmul(input logic [3:0] x, input logic [3:0] y);
    logic [3:0] p, s;
    p = '0;
    s = x;
    for (int i = 0; i < 4; i++) begin
      if (y[i]) p = p ^ s;
      s = {s[2:0], 1'b0} ^ (s[3] ? 4'b0011 : 4'b0000);
    end
    return p;
  endfunction

  function automatic logic [15:0] dcol(input int j);
    logic [3:0] a, b, q;
    a = j[3:0];
    b = j[4] ? 4'h3 : 4'h2;
    q = gmul(a, a) ^ gmul(a, b) ^ gmul(QC, gmul(b, b));
    return {q ^ a ^ gmul(QC, b), b, a, 4'h1 ^ a ^ b};
  endfunction

  function automatic logic [15:0] checks(input logic [127:0] d);
    logic [15:0] c, h;
    c = '0;
    for (int j = 0; j < NDATA; j++) begin
      h = dcol(j);
      for (int k = 0; k < NCHK; k++)
        c[4*k +: 4] = c[4*k +: 4] ^ gmul(d[4*j +: 4], h[4*k +: 4]);
    end
    return c;
  endfunction

  logic [15:0]           syn;
  logic [NSYM-1:0]       hit;
  logic [NSYM-1:0][3:0]  mag;
  logic [127:0]          corr;
  logic [5:0]            sym_idx;
  logic                  ce, ue;

  assign enc_check = checks(enc_data);
  assign syn       = checks(in_data) ^ in_check;

  for (genvar i = 0; i < NSYM; i++) begin : g_sym
    if (i < NDATA) begin : g_d
      localparam logic [15:0] H    = dcol(i);
      localparam logic [3:0]  BINV = (H[11:8] == 4'h2) ? 4'h9 : 4'hE;
      assign mag[i] = gmul(syn[11:8], BINV);
      assign hit[i] = (mag[i] != 4'h0) &&
                      ({gmul(mag[i], H[15:12]), gmul(mag[i], H[11:8]),
                        gmul(mag[i], H[7:4]),   gmul(mag[i], H[3:0])} == syn);
      assign corr[4*i +: 4] = in_data[4*i +: 4] ^ (hit[i] ? mag[i] : 4'h0);
    end else begin : g_c
      localparam int K = i - NDATA;
      assign mag[i] = syn[4*K +: 4];
      assign hit[i] = (mag[i] != 4'h0) && ((syn & ~(16'hF << (4*K))) == 16'h0);
    end
  end

  always_comb begin
    sym_idx = '0;
    for (int i = 0; i < NSYM; i++)
      if (hit[i]) sym_idx = 6'(i);
  end

  assign ce       = |hit;
  assign ue       = (syn != 16'h0) && !ce;
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_ce       <= 1'b0;
      out_ue       <= 1'b0;
      out_syndrome <= '0;
      out_sym      <= '0;
      out_upper    <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data     <= corr;
        out_ce       <= ce;
        out_ue       <= ue;
        out_syndrome <= syn;
        out_sym      <= sym_idx;
        out_upper    <= ce && sym_idx >= 6'd16 && sym_idx < 6'd32;
      end
    end
  end

  AST_ONE_SYMBOL_MATCH: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> $onehot0(hit)); // R3
  AST_CE_UE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !(out_ce && out_ue)); // R5
  AST_ZERO_SYN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_syndrome == 16'h0) |-> (!out_ce && !out_ue)); // R2
  AST_SYM_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_ce) |-> out_sym < 6'd36); // R3
  AST_UPPER_DATA: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_upper) |-> (out_ce && out_sym >= 6'd16 && out_sym < 6'd32)); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_syndrome))); // R8
endmodule

// File: tb/test_nyb_chipkill_codec.sv
module test_nyb_chipkill_codec;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] enc_data = '0;
  logic [15:0]  enc_check;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic [15:0]  in_check = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic         out_ce, out_ue, out_upper;
  logic [15:0]  out_syndrome;
  logic [5:0]   out_sym;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nyb_chipkill_codec i_nyb_chipkill_codec (.*);

  function automatic logic [3:0] rmul(input logic [3:0] x, input logic [3:0] y);
    logic [6:0] p;
    p = '0;
    for (int i = 0; i < 4; i++) if (y[i]) p = p ^ (7'(x) << i);
    for (int b = 6; b >= 4; b--) if (p[b]) p = p ^ (7'b0010011 << (b - 4));
    return p[3:0];
  endfunction

  function automatic logic [15:0] rchk(input logic [127:0] d);
    logic [15:0] c;
    logic [3:0] a, b, s;
    c = '0;
    for (int j = 0; j < 32; j++) begin
      a = 4'(j % 16);
      b = (j < 16) ? 4'd2 : 4'd3;
      s = d[4*j +: 4];
      c[3:0]   = c[3:0]   ^ rmul(s, 4'h1 ^ a ^ b);
      c[7:4]   = c[7:4]   ^ rmul(s, a);
      c[11:8]  = c[11:8]  ^ rmul(s, b);
      c[15:12] = c[15:12] ^ rmul(s, rmul(a, a) ^ rmul(a, b) ^ rmul(4'h8, rmul(b, b)) ^ a ^ rmul(4'h8, b));
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [127:0] d, input logic [15:0] c, input logic [127:0] xd,
                     input bit xce, input bit xue, input logic [5:0] xsym, input string req);
    logic [15:0] xsyn;
    bit xup;
    xsyn = rchk(d) ^ c;
    xup  = xce && xsym >= 16 && xsym < 32;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_check = c;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_data == xd && out_ce == xce && out_ue == xue && out_sym == xsym,
        req, {out_valid, out_ce, out_ue, out_sym, out_data[63:0]}, {1'b1, xce, xue, xsym, xd[63:0]});
    chk(out_syndrome == xsyn, "R6", 128'(out_syndrome), 128'(xsyn));
    chk(out_upper == xup, "R7", 128'(out_upper), 128'(xup));
  endtask

  initial begin
    logic [127:0] d, bd;
    logic [15:0] cw, bc;
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R9", {out_valid, in_ready}, 2'b01);
    #22 rst_n = 1'b1;

    for (int t = 0; t < 40; t++) begin
      enc_data = (t == 0) ? '0 : (t == 1) ? '1 : (t < 34) ? (128'hF << (4*(t-2))) : {$urandom, $urandom, $urandom, $urandom};
      #1;
      chk(enc_check == rchk(enc_data), "R1", 128'(enc_check), 128'(rchk(enc_data)));
    end

    for (int trial = 0; trial < 2; trial++) begin
      d  = {$urandom, $urandom, $urandom, $urandom};
      cw = rchk(d);
      run(d, cw, d, 1'b0, 1'b0, 6'd0, "R2");
      for (int i = 0; i < 36; i++) begin
        for (int e = 1; e < 16; e++) begin
          bd = d; bc = cw;
          if (i < 32) begin
            bd[4*i +: 4] = bd[4*i +: 4] ^ 4'(e);
            run(bd, bc, d, 1'b1, 1'b0, 6'(i), "R3");
          end else begin
            bc[4*(i-32) +: 4] = bc[4*(i-32) +: 4] ^ 4'(e);
            run(bd, bc, bd, 1'b1, 1'b0, 6'(i), "R4");
          end
        end
      end
    end

    for (int n = 0; n < 400; n++) begin
      int i, j;
      logic [3:0] e1, e2;
      d  = {$urandom, $urandom, $urandom, $urandom};
      cw = rchk(d);
      i  = int'($urandom % 36);
      j  = int'($urandom % 35);
      if (j >= i) j++;
      e1 = 4'($urandom % 15 + 1);
      e2 = 4'($urandom % 15 + 1);
      bd = d; bc = cw;
      if (i < 32) bd[4*i +: 4] ^= e1; else bc[4*(i-32) +: 4] ^= e1;
      if (j < 32) bd[4*j +: 4] ^= e2; else bc[4*(j-32) +: 4] ^= e2;
      run(bd, bc, bd, 1'b0, 1'b1, 6'd0, "R5");
    end

    d  = {$urandom, $urandom, $urandom, $urandom};
    bd = ~d;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = d; in_check = rchk(d);
    @(negedge clk);
    chk(out_valid && out_data == d, "R10", out_data, d);
    in_data = bd; in_check = rchk(bd);
    chk(in_ready == 1'b0, "R8", 128'(in_ready), 128'(0));
    repeat (3) @(negedge clk);
    chk(out_valid && out_data == d, "R8", out_data, d);
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R8", 128'(in_ready), 128'(1));
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_data == bd, "R10", out_data, bd);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", 128'(out_valid), 128'(0));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule